// File: doc/BRIEF.md
# Link Error Monitor Counter

This block watches the decoded symbol stream of a single physical link. It counts the code-level violations that the decoder flags, and it counts them whether the symbol sits inside a frame, inside a token or in the idle gap between packets. A violation of this kind is never passed on by the receiving port, so each error event is counted at exactly one port. Errors that turn one valid data symbol into another valid symbol cannot be seen at the code level and are outside the count.

Counting runs over windows of 2^N symbol times, where N is programmable. At the end of each window the saturating violation count is reported. A coarse severity figure, the bit length of that count, is reported with it and is the order of magnitude of the error rate in binary steps. When this figure reaches a programmable threshold in two consecutive windows, the block raises a sticky request to take the link out of service. Management clears the request through a dedicated input. One instance serves each port, so a fault is traced to one link.

Top module: `link_err_mon`

## Requirements
- R1: A violation counts only in a cycle where both `sym_vld` and `viol` are high; `viol` without `sym_vld` has no effect on any output.
- R2: A window is exactly 2^`win_log` symbols, counted on `sym_vld` only (values above `WIN_MAX_LOG` act as `WIN_MAX_LOG`). Idle cycles do not advance it. The outputs update on the clock edge that takes the window's last symbol.
- R3: The per-window violation count saturates at 2^`CNT_W`-1 and never wraps.
- R4: At a window end `err_cnt` shows the count of that window, including its final symbol, and the next window starts from zero.
- R5: `ber_exp` equals the bit length of `err_cnt`. It is 0 for a count of 0, and k for a count c with 2^(k-1) <= c < 2^k.
- R6: `fault_req` rises at a window end only when that window and the one before it both had `ber_exp` >= `thresh`; one such window alone never raises it.
- R7: A window whose `ber_exp` is below `thresh` breaks the run, so two qualifying windows with a non-qualifying one between them do not raise `fault_req`.
- R8: `fault_req` stays high until `fault_clr` is high at a clock edge. The clear also discards the run of qualifying windows and takes priority over a window end in the same cycle.
- R9: After `rst_n` low, `err_cnt`, `ber_exp` and `fault_req` are 0 and a new window starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_vld | input | 1 | A decoded symbol is present this cycle |
| viol | input | 1 | The present symbol is a code violation |
| win_log | input | WL_W | Window length exponent N (2^N symbols) |
| thresh | input | EXP_W | Severity level that qualifies a window |
| fault_clr | input | 1 | Clears the link-removal request |
| err_cnt | output | CNT_W | Violation count of the last complete window |
| ber_exp | output | EXP_W | Bit length of `err_cnt` |
| fault_req | output | 1 | Sticky request to remove the link |

## Verification
Error patterns are injected with a violation on every K-th symbol, over several window lengths. Zero, sparse, dense and all-symbol rates give counts that land inside one binary decade, exactly on a decade edge and past saturation, which separates off-by-one window ends, a wrong leading-one position and a wrapping counter. Idle cycles carrying stray violation flags show whether the count and the window length depend only on qualified symbols. Sequences of windows that qualify, miss and qualify again check the two-window rule, the broken run and the clear against the threshold comparison.

// File: rtl/link_err_mon.sv
module link_err_mon #(
  parameter int CNT_W       = 8,
  parameter int WIN_MAX_LOG = 16,
  parameter int WL_W        = $clog2(WIN_MAX_LOG + 1),
  parameter int EXP_W       = $clog2(CNT_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_vld,
  input  logic             viol,
  input  logic [WL_W-1:0]  win_log,
  input  logic [EXP_W-1:0] thresh,
  input  logic             fault_clr,
  output logic [CNT_W-1:0] err_cnt,
  output logic [EXP_W-1:0] ber_exp,
  output logic             fault_req
);

  localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

  function automatic logic [EXP_W-1:0] bitlen(input logic [CNT_W-1:0] v);
    bitlen = '0;
    for (int i = 0; i < CNT_W; i++)
      if (v[i]) bitlen = EXP_W'(i + 1);
  endfunction

  logic [WIN_MAX_LOG-1:0] sym_cnt;
  logic [CNT_W-1:0]       acc;
  logic                   hit_prev;

  logic [WL_W-1:0]        nsel;
  logic [WIN_MAX_LOG:0]   lim;
  logic                   win_end;
  logic [CNT_W-1:0]       acc_nxt;
  logic [EXP_W-1:0]       exp_nxt;
  logic                   hit;

  assign nsel    = (win_log > WL_W'(WIN_MAX_LOG)) ? WL_W'(WIN_MAX_LOG) : win_log;
  assign lim     = ((WIN_MAX_LOG+1)'(1) << nsel) - (WIN_MAX_LOG+1)'(1);
  assign win_end = sym_vld && ({1'b0, sym_cnt} >= lim);
  assign acc_nxt = (sym_vld && viol && acc != SAT) ? acc + CNT_W'(1) : acc;
  assign exp_nxt = bitlen(acc_nxt);
  assign hit     = exp_nxt >= thresh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_cnt   <= '0;
      acc       <= '0;
      hit_prev  <= 1'b0;
      err_cnt   <= '0;
      ber_exp   <= '0;
      fault_req <= 1'b0;
    end else begin
      if (win_end) begin
        sym_cnt   <= '0;
        acc       <= '0;
        err_cnt   <= acc_nxt;
        ber_exp   <= exp_nxt;
        hit_prev  <= hit;
        fault_req <= fault_req | (hit & hit_prev);
      end else if (sym_vld) begin
        sym_cnt <= sym_cnt + WIN_MAX_LOG'(1);
        acc     <= acc_nxt;
      end
      if (fault_clr) begin
        fault_req <= 1'b0;
        hit_prev  <= 1'b0;
      end
    end
  end

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_vld |=> $stable(acc) && $stable(sym_cnt) && $stable(err_cnt));

  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc == SAT && !win_end) |=> acc == SAT);

  p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> acc == '0 && sym_cnt == '0);

  p_exp_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_cnt >> ber_exp) == '0) && (ber_exp == '0 || err_cnt[ber_exp - EXP_W'(1)]));

  p_rise_on_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_req && !(win_end && !fault_clr)) |=> !fault_req);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_clr |=> !fault_req);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_req && !fault_clr) |=> fault_req);

endmodule

// File: tb/tb_link_err_mon.sv
module tb_link_err_mon;
  localparam int CNT_W = 8;
  localparam int WL_W  = 5;
  localparam int EXP_W = 4;

  logic clk = 0, rst_n = 0, sym_vld = 0, viol = 0, fault_clr = 0;
  logic [WL_W-1:0]  win_log = '0;
  logic [EXP_W-1:0] thresh = '0;
  logic [CNT_W-1:0] err_cnt;
  logic [EXP_W-1:0] ber_exp;
  logic             fault_req;

  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  link_err_mon #(.CNT_W(CNT_W), .WIN_MAX_LOG(16)) dut (
    .clk, .rst_n, .sym_vld, .viol, .win_log, .thresh, .fault_clr,
    .err_cnt, .ber_exp, .fault_req);

  // {win_log, every K-th symbol is a violation (0 = none), thresh, exp count, exp severity}
  localparam int NV = 8;
  localparam int VEC [NV][5] = '{
    '{4, 0, 3,   0, 0},
    '{4, 1, 5,  16, 5},
    '{6, 4, 6,  16, 5},
    '{6, 3, 5,  22, 5},
    '{8, 1, 8, 255, 8},
    '{8, 16, 4, 16, 5},
    '{5, 32, 1,  1, 1},
    '{3, 2, 4,   4, 3}
  };

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; sym_vld = 0; viol = 0; fault_clr = 0;
    @(negedge clk); rst_n = 1;
  endtask

  // one window of 2^n symbols, violation on symbol i when k>0 and i%k==0; gap idle cycles carry viol=1
  task automatic window(input int n, input int k, input bit gaps);
    for (int i = 0; i < (1 << n); i++) begin
      @(negedge clk);
      sym_vld = 1; viol = (k > 0) && (i % k == 0);
      if (gaps) begin
        @(negedge clk); sym_vld = 0; viol = 1;
      end
    end
    @(negedge clk); sym_vld = 0; viol = 0;
  endtask

  task automatic clear();
    @(negedge clk); fault_clr = 1;
    @(negedge clk); fault_clr = 0;
  endtask

  initial begin
    #400000;
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R9 reset state
    chk("R9 err_cnt", int'(err_cnt), 0);
    chk("R9 ber_exp", int'(ber_exp), 0);
    chk("R9 fault_req", int'(fault_req), 0);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      win_log = WL_W'(VEC[v][0]); thresh = EXP_W'(VEC[v][2]);
      window(VEC[v][0], VEC[v][1], 0);
      chk("R3/R4 count", int'(err_cnt), VEC[v][3]);
      chk("R5 severity", int'(ber_exp), VEC[v][4]);
      chk("R6 one window no fault", int'(fault_req), 0);
      window(VEC[v][0], VEC[v][1], 0);
      chk("R6 two windows", int'(fault_req), (VEC[v][4] >= VEC[v][2]) ? 1 : 0);
    end

    // R1: stray viol flags on idle cycles are ignored
    do_reset(); win_log = 4; thresh = 1;
    window(4, 0, 1);
    chk("R1 idle viol ignored cnt", int'(err_cnt), 0);
    chk("R1 idle viol ignored exp", int'(ber_exp), 0);

    // R2: window ends at 2^N symbols despite idle gaps; one symbol short leaves outputs unchanged
    do_reset(); win_log = 4;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk); sym_vld = 1; viol = 1;
      @(negedge clk); sym_vld = 0; viol = 0;
    end
    chk("R2 not yet ended", int'(err_cnt), 0);
    @(negedge clk); sym_vld = 1; viol = 1;
    @(negedge clk); sym_vld = 0; viol = 0;
    chk("R2 ended at 16th symbol", int'(err_cnt), 16);

    // R7: qualify, miss, qualify -> no fault; another qualify -> fault
    do_reset(); win_log = 4; thresh = 5;
    window(4, 1, 0);
    window(4, 0, 0);
    window(4, 1, 0);
    chk("R7 broken run", int'(fault_req), 0);
    window(4, 1, 0);
    chk("R7 run resumes", int'(fault_req), 1);

    // R8: sticky through a clean window, cleared, run discarded
    window(4, 0, 0);
    chk("R8 sticky", int'(fault_req), 1);
    clear();
    chk("R8 cleared", int'(fault_req), 0);
    window(4, 1, 0);
    chk("R8 run discarded", int'(fault_req), 0);
    window(4, 1, 0);
    chk("R8 refault", int'(fault_req), 1);

    // R8: clear coincident with a qualifying window end wins
    do_reset(); win_log = 3; thresh = 2;
    window(3, 1, 0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sym_vld = 1; viol = 1; fault_clr = (i == 7);
    end
    @(negedge clk); sym_vld = 0; viol = 0; fault_clr = 0;
    chk("R8 clear priority", int'(fault_req), 0);
    chk("R4 count with clear", int'(err_cnt), 8);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule